// File: doc/BRIEF.md
# Exclusive Bus Lock Acquisition Unit

This block sits beside a bus master and obtains exclusive use of a shared bus lock for an atomic read-modify-write sequence. Software raises a sequence request. The unit then requests the bus, but only while the shared lock line and the frame line are both free. It withdraws that request if another master takes the lock while it waits. It takes the lock once it holds a grant on an idle bus whose lock line is free. The lock stays driven across the first transaction and any continuation transactions. It is dropped one clock after the final data phase that follows software's completion pulse. If the first transaction is retried, the lock was not established, so the unit lets go and arbitrates again.

A small target-side guard is packaged alongside. Once an access completes while the lock line is asserted, the guard treats its agent as locked. From then on it retries any address phase that hits it while the lock line is still asserted. The locked condition ends when the bus returns to idle with the lock line free.

All bus pins are active-high "asserted" flags. Polarity conversion for the low-true bus wires happens outside this block.

Top module: `lockAcqUnit`

## Requirements
- R1: While `reqOut` is low and `busLock` is sampled high at a rising edge, `reqOut` stays low after that edge.
- R2: While `reqOut` is low and `busFrame` is sampled high at a rising edge, `reqOut` stays low after that edge. With `lockReq` high and both `busFrame` and `busLock` low, `reqOut` rises after one edge.
- R3: While waiting for a grant (`reqOut` high, `lockDrive` low), sampling `busLock` high drops `reqOut` at that edge. The request comes back once `busLock` and `busFrame` are low again.
- R4: `lockDrive` rises only after an edge at which `grant` is high, `busFrame`, `busIrdy` and `busLock` are all low, and a request is outstanding.
- R5: If the first locked transaction ends with a final data phase (`busIrdy`, `busTrdy` high, `busFrame` low) and no completion pulse is pending, the unit keeps `lockDrive` high and raises `lockHeld`.
- R6: After a `lockDone` pulse during the sequence, `lockDrive` and `lockHeld` stay high through the cycle of the next final data phase. Both are low after the edge that samples that phase.
- R7: A retry (`busStop` high, `busTrdy` low) during the first locked transaction drops `lockDrive` after that edge. With `lockReq` still high, the unit requests again from idle.
- R8: A `lockDone` pulse while no sequence is active has no effect: a later first transaction still leaves the lock held.
- R9: Once an access hitting the guard completes with `busLock` high, any later address phase that hits it with `busLock` high raises `tgtRetry` after one edge. `tgtRetry` falls after `busFrame` is sampled low. An address phase that hits it with `busLock` low is not retried.
- R10: The guard's locked condition clears at an edge where `busFrame` and `busLock` are both low. After that, hits with `busLock` high are not retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lockReq | input | 1 | Software asks for an exclusive sequence (level) |
| lockDone | input | 1 | Software pulse: the next final data phase ends the sequence |
| grant | input | 1 | Bus grant for this master |
| busFrame | input | 1 | Frame line asserted |
| busIrdy | input | 1 | Initiator-ready line asserted |
| busTrdy | input | 1 | Target-ready line asserted |
| busStop | input | 1 | Stop line asserted |
| busLock | input | 1 | Shared lock line asserted (observed) |
| reqOut | output | 1 | Bus request from this master |
| lockDrive | output | 1 | This master drives the lock line |
| lockHeld | output | 1 | Lock established and held |
| tgtHit | input | 1 | Guarded agent is addressed by the current access |
| tgtAddrPhase | input | 1 | Current cycle is an address phase |
| tgtDataDone | input | 1 | A data phase to the guarded agent completes |
| tgtRetry | output | 1 | Guard signals retry to the current access |

## Verification
The assertions assume the bus flags follow protocol. A completion is shown only as `busIrdy` with `busTrdy` and `busFrame` low, and a retry only as `busStop` with `busTrdy` low. The observed `busLock` reflects other agents whenever this master is not driving the lock. The directed scenarios change inputs only at falling edges. They present these conditions one at a time, each on a bus that starts idle. The guard scenarios run while the master side is idle, so the shared lock line is driven only by the bench.

// File: rtl/lockPkg.sv
package lockPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_FIRST = 2'd2,
    ST_HELD  = 2'd3
  } lockState_t;

  typedef struct packed {
    logic setReq;
    logic clrReq;
    logic setLock;
    logic clrLock;
    logic setHeld;
    logic clrHeld;
    logic capDone;
    logic clrDone;
  } lockStrobe_t;

endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import lockPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lockReq,
  input  logic        lockDone,
  input  logic        grant,
  input  logic        busFrame,
  input  logic        busIrdy,
  input  logic        busTrdy,
  input  logic        busStop,
  input  logic        busLock,
  input  logic        donePending,
  output lockStrobe_t strobe
);

  lockState_t state, stateNxt;

  logic busIdle, finalPhase, retryEv, ownNow, endNow;

  assign busIdle    = !busFrame && !busIrdy;
  assign finalPhase = busIrdy && busTrdy && !busFrame;
  assign retryEv    = busStop && !busTrdy;
  assign ownNow     = grant && busIdle && !busLock;
  assign endNow     = finalPhase && (donePending || lockDone);

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_IDLE: begin
        if (lockReq && !busFrame && !busLock) begin
          stateNxt      = ST_ARB;
          strobe.setReq = 1'b1;
        end
      end
      ST_ARB: begin
        if (busLock) begin
          stateNxt      = ST_IDLE;
          strobe.clrReq = 1'b1;
        end else if (ownNow) begin
          stateNxt       = ST_FIRST;
          strobe.setLock = 1'b1;
        end
      end
      ST_FIRST: begin
        strobe.capDone = lockDone;
        if (retryEv) begin
          stateNxt       = ST_IDLE;
          strobe.clrLock = 1'b1;
          strobe.clrReq  = 1'b1;
          strobe.clrDone = 1'b1;
          strobe.capDone = 1'b0;
        end else if (endNow) begin
          stateNxt       = ST_IDLE;
          strobe.clrLock = 1'b1;
          strobe.clrReq  = 1'b1;
          strobe.clrDone = 1'b1;
          strobe.capDone = 1'b0;
        end else if (finalPhase) begin
          stateNxt       = ST_HELD;
          strobe.setHeld = 1'b1;
        end
      end
      ST_HELD: begin
        strobe.capDone = lockDone;
        if (endNow) begin
          stateNxt       = ST_IDLE;
          strobe.clrLock = 1'b1;
          strobe.clrReq  = 1'b1;
          strobe.clrHeld = 1'b1;
          strobe.clrDone = 1'b1;
          strobe.capDone = 1'b0;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  // R8: a completion pulse is only captured inside an active sequence
  idle_done_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_ARB) |-> !strobe.capDone);

endmodule

// File: rtl/lockPath.sv
module lockPath
  import lockPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lockStrobe_t strobe,
  output logic        reqOut,
  output logic        lockDrive,
  output logic        lockHeld,
  output logic        donePending
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOut      <= 1'b0;
      lockDrive   <= 1'b0;
      lockHeld    <= 1'b0;
      donePending <= 1'b0;
    end else begin
      if (strobe.setReq)       reqOut <= 1'b1;
      else if (strobe.clrReq)  reqOut <= 1'b0;

      if (strobe.setLock)      lockDrive <= 1'b1;
      else if (strobe.clrLock) lockDrive <= 1'b0;

      if (strobe.setHeld)      lockHeld <= 1'b1;
      else if (strobe.clrHeld) lockHeld <= 1'b0;

      if (strobe.clrDone)      donePending <= 1'b0;
      else if (strobe.capDone) donePending <= 1'b1;
    end
  end

  // R5: the held status never shows without the lock being driven
  held_needs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockHeld |-> lockDrive);

endmodule

// File: rtl/lockTgtGuard.sv
module lockTgtGuard (
  input  logic clk,
  input  logic rstN,
  input  logic busFrame,
  input  logic busLock,
  input  logic tgtHit,
  input  logic tgtAddrPhase,
  input  logic tgtDataDone,
  output logic tgtRetry
);

  logic agentLocked;
  logic lockedNxt;

  always_comb begin
    lockedNxt = agentLocked;
    if (tgtDataDone && tgtHit && busLock) lockedNxt = 1'b1;
    else if (!busFrame && !busLock)       lockedNxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      agentLocked <= 1'b0;
      tgtRetry    <= 1'b0;
    end else begin
      agentLocked <= lockedNxt;
      if (agentLocked && tgtAddrPhase && tgtHit && busLock) tgtRetry <= 1'b1;
      else if (!busFrame)                                   tgtRetry <= 1'b0;
    end
  end

  // R9: a retry starts only from a locked hit carrying the lock line
  retry_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtRetry) |-> $past(tgtAddrPhase && tgtHit && busLock));

  // R10: the guard stays unlocked right after an idle, lock-free cycle
  unlock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busFrame && !busLock && !tgtDataDone) |=> !agentLocked);

endmodule

// File: rtl/lockAcqUnit.sv
module lockAcqUnit
  import lockPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lockReq,
  input  logic lockDone,
  input  logic grant,
  input  logic busFrame,
  input  logic busIrdy,
  input  logic busTrdy,
  input  logic busStop,
  input  logic busLock,
  output logic reqOut,
  output logic lockDrive,
  output logic lockHeld,
  input  logic tgtHit,
  input  logic tgtAddrPhase,
  input  logic tgtDataDone,
  output logic tgtRetry
);

  lockStrobe_t strobe;
  logic        donePending;

  lockCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lockReq     (lockReq),
    .lockDone    (lockDone),
    .grant       (grant),
    .busFrame    (busFrame),
    .busIrdy     (busIrdy),
    .busTrdy     (busTrdy),
    .busStop     (busStop),
    .busLock     (busLock),
    .donePending (donePending),
    .strobe      (strobe)
  );

  lockPath uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqOut      (reqOut),
    .lockDrive   (lockDrive),
    .lockHeld    (lockHeld),
    .donePending (donePending)
  );

  lockTgtGuard uGuard (
    .clk          (clk),
    .rstN         (rstN),
    .busFrame     (busFrame),
    .busLock      (busLock),
    .tgtHit       (tgtHit),
    .tgtAddrPhase (tgtAddrPhase),
    .tgtDataDone  (tgtDataDone),
    .tgtRetry     (tgtRetry)
  );

  // R1
  req_lock_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqOut && busLock) |=> !reqOut);

  // R2
  req_frame_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqOut && busFrame) |=> !reqOut);

  // R3
  req_withdraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut && !lockDrive && busLock) |=> !reqOut);

  // R4
  own_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockDrive) |-> $past(grant && !busFrame && !busIrdy && !busLock && reqOut));

  // R6
  release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockDrive) |-> $past((busIrdy && busTrdy && !busFrame) || (busStop && !busTrdy)));

endmodule

// File: tb/sim_lockAcqUnit.sv
module sim_lockAcqUnit;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lockReq = 0, lockDone = 0, grant = 0;
  logic busFrame = 0, busIrdy = 0, busTrdy = 0, busStop = 0, busLock = 0;
  logic tgtHit = 0, tgtAddrPhase = 0, tgtDataDone = 0;
  logic reqOut, lockDrive, lockHeld, tgtRetry;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lockAcqUnit u0 (
    .clk(clk), .rstN(rstN), .lockReq(lockReq), .lockDone(lockDone), .grant(grant),
    .busFrame(busFrame), .busIrdy(busIrdy), .busTrdy(busTrdy), .busStop(busStop),
    .busLock(busLock), .reqOut(reqOut), .lockDrive(lockDrive), .lockHeld(lockHeld),
    .tgtHit(tgtHit), .tgtAddrPhase(tgtAddrPhase), .tgtDataDone(tgtDataDone),
    .tgtRetry(tgtRetry)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic busQuiet();
    busFrame = 0; busIrdy = 0; busTrdy = 0; busStop = 0; busLock = 0; grant = 0;
    tgtHit = 0; tgtAddrPhase = 0; tgtDataDone = 0; lockDone = 0;
  endtask

  task automatic doReset();
    rstN = 0; lockReq = 0; busQuiet();
    repeat (3) tick();
    rstN = 1;
    tick();
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "reset reqOut", reqOut, 1'b0);
    chk("R4", "reset lockDrive", lockDrive, 1'b0);
    chk("R5", "reset lockHeld", lockHeld, 1'b0);
    chk("R9", "reset tgtRetry", tgtRetry, 1'b0);
  endtask

  // R1, R2: gating of the request by the lock and frame lines
  task automatic testGating();
    doReset();
    lockReq = 1; busLock = 1;
    tick(); tick();
    chk("R1", "no request while lock busy", reqOut, 1'b0);
    busLock = 0; busFrame = 1;
    tick(); tick();
    chk("R2", "no request while frame busy", reqOut, 1'b0);
    busFrame = 0;
    tick();
    chk("R2", "request once both free", reqOut, 1'b1);
  endtask

  // R3: withdraw on foreign lock during arbitration
  task automatic testWithdraw();
    doReset();
    lockReq = 1;
    tick();
    chk("R3", "request raised", reqOut, 1'b1);
    busLock = 1;
    tick();
    chk("R3", "request withdrawn", reqOut, 1'b0);
    busLock = 0;
    tick();
    chk("R3", "request restored", reqOut, 1'b1);
  endtask

  // Brings the unit to the first locked transaction
  task automatic acquire();
    doReset();
    lockReq = 1;
    tick();
    grant = 1;
    tick();
  endtask

  // R4: ownership needs an idle bus
  task automatic testOwnership();
    doReset();
    lockReq = 1;
    tick();
    grant = 1; busIrdy = 1;
    tick(); tick();
    chk("R4", "no lock while irdy busy", lockDrive, 1'b0);
    busIrdy = 0;
    tick();
    chk("R4", "lock taken on idle bus", lockDrive, 1'b1);
  endtask

  // R5, R6: establish, continue and release
  task automatic testSequence();
    acquire();
    busFrame = 1;
    tick();
    busFrame = 0; busIrdy = 1; busTrdy = 1;
    tick();
    busIrdy = 0; busTrdy = 0;
    chk("R5", "held after first transaction", lockHeld, 1'b1);
    chk("R5", "lock kept after first transaction", lockDrive, 1'b1);
    tick();
    busFrame = 1; lockDone = 1;
    tick();
    lockDone = 0; lockReq = 0;
    chk("R6", "lock still driven before final phase", lockDrive, 1'b1);
    busFrame = 0; busIrdy = 1; busTrdy = 1;
    tick();
    busIrdy = 0; busTrdy = 0;
    chk("R6", "lock released after final phase", lockDrive, 1'b0);
    chk("R6", "held cleared after final phase", lockHeld, 1'b0);
  endtask

  // R7: retry on the first locked transaction
  task automatic testRetryFirst();
    acquire();
    busFrame = 1; busIrdy = 1; busStop = 1;
    tick();
    busFrame = 0; busIrdy = 0; busStop = 0; grant = 0;
    chk("R7", "lock dropped on retry", lockDrive, 1'b0);
    chk("R7", "not held after retry", lockHeld, 1'b0);
    tick();
    chk("R7", "request again after retry", reqOut, 1'b1);
  endtask

  // R8: completion pulse outside a sequence is ignored
  task automatic testDoneIgnored();
    doReset();
    lockDone = 1;
    tick();
    lockDone = 0;
    lockReq = 1;
    tick();
    grant = 1;
    tick();
    busFrame = 1;
    tick();
    busFrame = 0; busIrdy = 1; busTrdy = 1;
    tick();
    busIrdy = 0; busTrdy = 0;
    chk("R8", "stray done left lock driven", lockDrive, 1'b1);
    chk("R8", "stray done left lock held", lockHeld, 1'b1);
  endtask

  // R9, R10: target-side guard
  task automatic testGuard();
    doReset();
    busFrame = 1; busLock = 1; tgtHit = 1; tgtDataDone = 1;
    tick();
    tgtDataDone = 0; tgtAddrPhase = 1;
    tick();
    tgtAddrPhase = 0;
    chk("R9", "foreign locked hit retried", tgtRetry, 1'b1);
    busFrame = 0;
    tick();
    chk("R9", "retry ends with frame", tgtRetry, 1'b0);
    busFrame = 1; busLock = 0; tgtAddrPhase = 1;
    tick();
    tgtAddrPhase = 0;
    chk("R9", "hit without lock line not retried", tgtRetry, 1'b0);
    busFrame = 0; busLock = 0; tgtHit = 0;
    tick();
    busFrame = 1; busLock = 1; tgtHit = 1; tgtAddrPhase = 1;
    tick();
    tgtAddrPhase = 0;
    chk("R10", "unlocked agent not retried", tgtRetry, 1'b0);
    busQuiet();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testGating();
    testWithdraw();
    testOwnership();
    testSequence();
    testRetryFirst();
    testDoneIgnored();
    testGuard();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule